// File: doc/BRIEF.md
# Image Sensor Register Sequencer (I2C Master)

This block is a two-wire serial master that programs and reads back the control registers of an image sensor. A host register file presents a 7-bit device address, a speed select, a read/write select, a 3-bit byte count and a five-byte window. The window holds the sensor register index in its lowest byte and up to four data bytes above it. A one-cycle launch pulse starts a transaction. The block then drives the clock line and the open-drain data line without further help until the transaction ends. While it works it holds ready low. When it finishes it raises ready, and an error flag shows whether every byte was acknowledged.

A write is a burst. The block sends the address byte with the direction bit clear, then the register index, then the data bytes. The sensor stores them at consecutive registers. A read always takes two phases. First comes a dummy write of the register index, closed by a stop. Then a fresh start, the address byte with the direction bit set, and exactly one byte from the sensor. The master leaves that byte unacknowledged, issues a stop, and returns the byte on a parallel output.

Bit timing is built from quarter periods of the system clock. A divider with two parameterised quarter lengths sets the standard and fast rates. The data line moves only while the clock line is low, except at start and stop.

Top module: `sensor_i2c_master`

## Requirements
- R1: After reset, ready_o is 1, err_o is 0, scl_o is 1 and sda_oe_o is 0 (data line released).
- R2: A write transaction shows exactly one start (data falls while clock high) and one stop (data rises while clock high). A read shows exactly two of each. No other data-line change occurs while the clock is high.
- R3: Every byte goes out MSB first. The first byte after each start is dev_addr_i in bits 7:1 with the direction bit in bit 0 (0 = write, 1 = read).
- R4: A write sends win_i[7:0] as the register index, then N data bytes, taken in order from win_i[15:8], win_i[23:16], win_i[31:24] and win_i[39:32]. N equals byte_cnt_i when that is 0 to 4 and is 4 for the values 5 to 7. The bytes land at consecutive registers starting at the index.
- R5: A read sends the address byte (bit 0 = 0) and the register index, then a stop, then a start and the address byte (bit 0 = 1). It clocks in one byte with the data line released in the 9th slot (no acknowledge) and ends with a stop. The byte appears on rd_data_o when ready_o returns to 1. byte_cnt_i and the data bytes of the window play no part in a read.
- R6: A byte that the slave does not acknowledge sets err_o to 1. No further byte is sent, a stop follows, and ready_o returns to 1.
- R7: During address and data bits, the clock line stays high for 2*QTR_FAST system cycles when the transaction was launched with fast_i = 1, and for 2*QTR_SLOW cycles when launched with fast_i = 0.
- R8: ready_o is 0 from the cycle after an accepted launch until the final stop completes. Launch pulses while ready_o is 0 have no effect.
- R9: err_o is cleared when the next transaction is launched and stays 0 if that transaction is fully acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle launch pulse, taken only while ready_o is 1 |
| rd_sel_i | input | 1 | 1 = single-byte read, 0 = write burst |
| fast_i | input | 1 | 1 = fast rate (QTR_FAST), 0 = standard rate (QTR_SLOW) |
| dev_addr_i | input | 7 | Slave device address |
| byte_cnt_i | input | 3 | Number of data bytes for a write (capped at 4) |
| win_i | input | 40 | Byte 0 = register index, bytes 1 to 4 = write data |
| ready_o | output | 1 | 1 = idle and able to accept a launch |
| err_o | output | 1 | 1 = last transaction met a missing acknowledge |
| rd_data_o | output | 8 | Byte returned by the last read |
| scl_o | output | 1 | Serial clock line |
| sda_oe_o | output | 1 | 1 = pull the data line low, 0 = release it |
| sda_i | input | 1 | Sampled level of the data line |

## Verification
The bench runs a bus-level slave model and sweeps every byte count at both rates. It catches a design that caps the burst wrongly: that design writes past the window or drops a byte, so a sentinel register is overwritten or the stored count comes up short. Reads at several indexes check the stop-then-restart framing and the released ninth slot. A design that acknowledges its own read byte, or that chains the phases with a repeated start, gives the wrong start/stop totals or a low acknowledge bit. Missing acknowledges are injected on the address byte and on a mid-burst data byte. A design that keeps sending after the failure stores extra bytes, and one that never sets or never clears the error flag shows the wrong flag value. A launch pulse injected mid-transfer exposes a design that restarts while busy, because the registers or the start count change.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

    localparam int WIN_BYTES = 5;
    localparam int WIN_W     = 8 * WIN_BYTES;
    localparam int IDX_W     = $clog2(WIN_BYTES + 1);

    typedef enum logic [1:0] {
        BC_START = 2'd0,
        BC_STOP  = 2'd1,
        BC_WR    = 2'd2,
        BC_RD    = 2'd3
    } bitcmd_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_START,
        SQ_TX,
        SQ_TXACK,
        SQ_RX,
        SQ_RXNACK,
        SQ_STOP
    } seq_state_e;

    typedef struct packed {
        logic scl;
        logic oe;
    } line_t;

    // Line levels for quarter ph of a bit-level command.
    function automatic line_t line_drive(bitcmd_e c, logic [1:0] ph, logic b);
        line_t r;
        unique case (c)
            BC_START: begin
                r.scl = (ph != 2'd3);
                r.oe  = ph[1];
            end
            BC_STOP: begin
                r.scl = (ph != 2'd0);
                r.oe  = (ph != 2'd3);
            end
            BC_WR: begin
                r.scl = (ph == 2'd1) || (ph == 2'd2);
                r.oe  = ~b;
            end
            default: begin
                r.scl = (ph == 2'd1) || (ph == 2'd2);
                r.oe  = 1'b0;
            end
        endcase
        return r;
    endfunction

    // Data bytes actually sent for a requested count.
    function automatic logic [IDX_W-1:0] data_count(logic [2:0] cnt);
        if (int'(cnt) > WIN_BYTES - 1)
            return IDX_W'(WIN_BYTES - 1);
        return IDX_W'(cnt);
    endfunction

    function automatic logic [7:0] pick_byte(logic [WIN_W-1:0] w, logic [IDX_W-1:0] k);
        logic [7:0] r;
        r = 8'h00;
        for (int j = 0; j < WIN_BYTES; j++) begin
            if (k == IDX_W'(j))
                r = w[8*j +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/i2c_qtick.sv
module i2c_qtick #(
    parameter int QTR_SLOW = 60,
    parameter int QTR_FAST = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    input  logic fast,
    output logic tick
);
    localparam int QMAX = (QTR_SLOW > QTR_FAST) ? QTR_SLOW : QTR_FAST;
    localparam int CW   = $clog2(QMAX + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    assign lim  = fast ? CW'(QTR_FAST - 1) : CW'(QTR_SLOW - 1);
    assign tick = run && !clr && (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst || clr || !run)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + CW'(1);
    end

    assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= lim));

endmodule

// File: rtl/i2c_bit_ctl.sv
module i2c_bit_ctl
    import i2c_seq_pkg::*;
#(
    parameter int QTR_SLOW = 60,
    parameter int QTR_FAST = 15
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    fast,
    input  logic    go,
    input  bitcmd_e cmd,
    input  logic    din,
    output logic    busy,
    output logic    done,
    output logic    dout,
    output logic    scl_o,
    output logic    sda_oe_o,
    input  logic    sda_i
);
    bitcmd_e    cmd_q;
    logic       din_q;
    logic [1:0] ph;
    line_t      line_r;
    logic       tick;
    logic       accept;

    assign accept = go && !busy;

    i2c_qtick #(.QTR_SLOW(QTR_SLOW), .QTR_FAST(QTR_FAST)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .clr  (accept),
        .run  (busy),
        .fast (fast),
        .tick (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= BC_STOP;
            din_q  <= 1'b1;
            ph     <= 2'd0;
            busy   <= 1'b0;
            done   <= 1'b0;
            dout   <= 1'b1;
            line_r <= '{scl: 1'b1, oe: 1'b0};
        end else begin
            done <= 1'b0;
            if (accept) begin
                cmd_q  <= cmd;
                din_q  <= din;
                ph     <= 2'd0;
                busy   <= 1'b1;
                line_r <= line_drive(cmd, 2'd0, din);
            end else if (busy && tick) begin
                if (ph == 2'd2)
                    dout <= sda_i;
                if (ph == 2'd3) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    ph     <= ph + 2'd1;
                    line_r <= line_drive(cmd_q, ph + 2'd1, din_q);
                end
            end
        end
    end

    assign scl_o    = line_r.scl;
    assign sda_oe_o = line_r.oe;

    // R2: data moves under a high clock only inside start or stop
    assert_sda_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (line_r.scl && $past(line_r.scl) && (line_r.oe != $past(line_r.oe)))
            |-> (cmd_q == BC_START || cmd_q == BC_STOP));

    assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy));

endmodule

// File: rtl/sensor_i2c_master.sv
module sensor_i2c_master
    import i2c_seq_pkg::*;
#(
    parameter int QTR_SLOW = 60,
    parameter int QTR_FAST = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             rd_sel_i,
    input  logic             fast_i,
    input  logic [6:0]       dev_addr_i,
    input  logic [2:0]       byte_cnt_i,
    input  logic [WIN_W-1:0] win_i,
    output logic             ready_o,
    output logic             err_o,
    output logic [7:0]       rd_data_o,
    output logic             scl_o,
    output logic             sda_oe_o,
    input  logic             sda_i
);
    seq_state_e       st;
    logic             pend;
    logic [6:0]       addr_q;
    logic             rd_q;
    logic             fast_q;
    logic [IDX_W-1:0] nd_q;
    logic [WIN_W-1:0] win_q;
    logic             phase2;
    logic [IDX_W-1:0] byte_i;
    logic [2:0]       bit_i;
    logic [7:0]       rx_sh;

    logic             go;
    bitcmd_e          eng_cmd;
    logic             eng_din;
    logic             eng_busy;
    logic             eng_done;
    logic             eng_dout;
    logic [7:0]       cur_byte;
    logic [IDX_W-1:0] last_idx;

    assign go = (st != SQ_IDLE) && !pend;

    always_comb begin
        if (byte_i == '0)
            cur_byte = {addr_q, phase2};
        else
            cur_byte = pick_byte(win_q, byte_i - IDX_W'(1));
    end

    always_comb begin
        if (!rd_q)
            last_idx = nd_q + IDX_W'(1);
        else if (!phase2)
            last_idx = IDX_W'(1);
        else
            last_idx = '0;
    end

    always_comb begin
        eng_cmd = BC_STOP;
        eng_din = 1'b1;
        unique case (st)
            SQ_START:  eng_cmd = BC_START;
            SQ_TX: begin
                eng_cmd = BC_WR;
                eng_din = cur_byte[3'd7 - bit_i];
            end
            SQ_TXACK:  eng_cmd = BC_RD;
            SQ_RX:     eng_cmd = BC_RD;
            SQ_RXNACK: eng_cmd = BC_WR;
            default:   eng_cmd = BC_STOP;
        endcase
    end

    i2c_bit_ctl #(.QTR_SLOW(QTR_SLOW), .QTR_FAST(QTR_FAST)) u_bit (
        .clk      (clk),
        .rst      (rst),
        .fast     (fast_q),
        .go       (go),
        .cmd      (eng_cmd),
        .din      (eng_din),
        .busy     (eng_busy),
        .done     (eng_done),
        .dout     (eng_dout),
        .scl_o    (scl_o),
        .sda_oe_o (sda_oe_o),
        .sda_i    (sda_i)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= SQ_IDLE;
            pend      <= 1'b0;
            addr_q    <= '0;
            rd_q      <= 1'b0;
            fast_q    <= 1'b0;
            nd_q      <= '0;
            win_q     <= '0;
            phase2    <= 1'b0;
            byte_i    <= '0;
            bit_i     <= '0;
            rx_sh     <= '0;
            rd_data_o <= '0;
            err_o     <= 1'b0;
        end else begin
            if (go)
                pend <= 1'b1;
            else if (eng_done)
                pend <= 1'b0;

            unique case (st)
                SQ_IDLE: begin
                    if (start_i) begin
                        addr_q <= dev_addr_i;
                        rd_q   <= rd_sel_i;
                        fast_q <= fast_i;
                        nd_q   <= data_count(byte_cnt_i);
                        win_q  <= win_i;
                        phase2 <= 1'b0;
                        byte_i <= '0;
                        bit_i  <= '0;
                        err_o  <= 1'b0;
                        st     <= SQ_START;
                    end
                end
                SQ_START: if (eng_done) begin
                    bit_i <= '0;
                    st    <= SQ_TX;
                end
                SQ_TX: if (eng_done) begin
                    if (bit_i == 3'd7)
                        st <= SQ_TXACK;
                    else
                        bit_i <= bit_i + 3'd1;
                end
                SQ_TXACK: if (eng_done) begin
                    bit_i <= '0;
                    if (eng_dout) begin
                        err_o <= 1'b1;
                        st    <= SQ_STOP;
                    end else if (byte_i != last_idx) begin
                        byte_i <= byte_i + IDX_W'(1);
                        st     <= SQ_TX;
                    end else if (rd_q && phase2) begin
                        st <= SQ_RX;
                    end else begin
                        st <= SQ_STOP;
                    end
                end
                SQ_RX: if (eng_done) begin
                    rx_sh <= {rx_sh[6:0], eng_dout};
                    if (bit_i == 3'd7)
                        st <= SQ_RXNACK;
                    else
                        bit_i <= bit_i + 3'd1;
                end
                SQ_RXNACK: if (eng_done) begin
                    rd_data_o <= rx_sh;
                    st        <= SQ_STOP;
                end
                SQ_STOP: if (eng_done) begin
                    if (rd_q && !phase2 && !err_o) begin
                        phase2 <= 1'b1;
                        byte_i <= '0;
                        st     <= SQ_START;
                    end else begin
                        st <= SQ_IDLE;
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    assign ready_o = (st == SQ_IDLE);

    assert_ready_idle_R8: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> !eng_busy);

    assert_err_abort_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(err_o) |-> (st == SQ_STOP));

    assert_byte_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_TX) |-> (byte_i <= last_idx));

    assert_read_only_R5: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_RX || st == SQ_RXNACK) |-> (rd_q && phase2));

endmodule

// File: tb/sim_sensor_i2c_master.sv
module sim_sensor_i2c_master;
    localparam int QS  = 5;
    localparam int QF  = 2;
    localparam logic [6:0] SLV = 7'h3C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        rd_sel_i = 1'b0;
    logic        fast_i = 1'b0;
    logic [6:0]  dev_addr_i = SLV;
    logic [2:0]  byte_cnt_i = 3'd0;
    logic [39:0] win_i = '0;
    logic        ready_o, err_o, scl_o, sda_oe_o;
    logic [7:0]  rd_data_o;
    logic        drv = 1'b0;
    logic        sda_line;

    assign sda_line = ~(sda_oe_o | drv);

    always #2 clk = ~clk;

    sensor_i2c_master #(.QTR_SLOW(QS), .QTR_FAST(QF)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .rd_sel_i(rd_sel_i),
        .fast_i(fast_i), .dev_addr_i(dev_addr_i), .byte_cnt_i(byte_cnt_i),
        .win_i(win_i), .ready_o(ready_o), .err_o(err_o), .rd_data_o(rd_data_o),
        .scl_o(scl_o), .sda_oe_o(sda_oe_o), .sda_i(sda_line)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // bus slave model state
    logic [7:0] mem [0:255];
    logic [7:0] ptr, sh, addr_seen;
    logic pscl = 1'b1, psda = 1'b1;
    bit in_xfer = 0, skip = 0, is_read = 0, acked = 0;
    int bitn = 0, byte_no = 0, nack_at = -1;
    int starts = 0, stops = 0, wrbytes = 0;
    logic mack = 1'b0;
    int hcnt = 0, hmin = 1000, hmax = 0;

    always @(negedge clk) begin
        if (scl_o && pscl && psda && !sda_line) begin
            starts++; in_xfer = 1; skip = 1; bitn = 0; byte_no = 0;
            is_read = 0; acked = 0; drv = 1'b0;
        end else if (scl_o && pscl && !psda && sda_line) begin
            stops++; in_xfer = 0; drv = 1'b0;
        end else if (scl_o && !pscl) begin
            if (in_xfer) begin
                if (bitn < 8) sh = {sh[6:0], sda_line};
                else if (is_read && byte_no == 1) mack = sda_line;
            end
        end else if (!scl_o && pscl) begin
            if (skip) skip = 0;
            else if (in_xfer) begin
                if (hcnt < hmin) hmin = hcnt;
                if (hcnt > hmax) hmax = hcnt;
                bitn++;
                if (bitn == 8) begin
                    if (byte_no == 0) begin
                        addr_seen = sh; is_read = sh[0];
                        acked = (sh[7:1] == SLV) && (nack_at != 0);
                        drv = acked;
                    end else if (!is_read) begin
                        if (nack_at == byte_no) drv = 1'b0;
                        else begin
                            drv = 1'b1;
                            if (byte_no == 1) ptr = sh;
                            else begin mem[ptr] = sh; ptr = ptr + 8'd1; wrbytes++; end
                        end
                    end else drv = 1'b0;
                end else if (bitn == 9) begin
                    bitn = 0; byte_no++; drv = 1'b0;
                    if (is_read && acked && byte_no == 1) drv = ~mem[ptr][7];
                end else if (is_read && acked && byte_no == 1 && bitn < 8) begin
                    drv = ~mem[ptr][7-bitn];
                end
            end
        end
        hcnt = scl_o ? hcnt + 1 : 0;
        pscl = scl_o;
        psda = ~(sda_oe_o | drv);
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_bus;
        for (int i = 0; i < 256; i++) mem[i] = 8'h5A;
        starts = 0; stops = 0; wrbytes = 0; hmin = 1000; hmax = 0; mack = 1'b0;
        addr_seen = 8'h00;
    endtask

    task automatic launch(input logic rd, input logic f, input logic [6:0] a,
                          input logic [2:0] c, input logic [39:0] w);
        @(negedge clk);
        rd_sel_i = rd; fast_i = f; dev_addr_i = a; byte_cnt_i = c; win_i = w;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_ready;
        int n = 0;
        while (!ready_o && n < 50000) begin @(negedge clk); n++; end
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [7:0] dgen(int c, int i, int f);
        return 8'(8'hC3 + c*17 + i*29 + f*5);
    endfunction

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(ready_o == 1'b1, "R1", "ready", ready_o, 1);
        chk(err_o == 1'b0, "R1", "err", err_o, 0);
        chk(scl_o == 1'b1 && sda_oe_o == 1'b0, "R1", "lines", {scl_o, sda_oe_o}, 2);

        // write sweep: every count at both rates
        for (int f = 0; f < 2; f++) begin
            for (int c = 0; c < 8; c++) begin
                logic [39:0] w;
                logic [7:0] sub;
                int n;
                n = (c > 4) ? 4 : c;
                sub = 8'(8'h10 + c*8 + f*64);
                w = {dgen(c,3,f), dgen(c,2,f), dgen(c,1,f), dgen(c,0,f), sub};
                clear_bus();
                launch(1'b0, f[0], SLV, c[2:0], w);
                chk(ready_o == 1'b0, "R8", "busy after launch", ready_o, 0);
                wait_ready();
                chk(err_o == 1'b0, "R4", "no error", err_o, 0);
                chk(addr_seen == {SLV, 1'b0}, "R3", "address byte", addr_seen, {SLV, 1'b0});
                chk(starts == 1 && stops == 1, "R2", "write framing", starts*16+stops, 17);
                chk(wrbytes == n, "R4", "stored count", wrbytes, n);
                for (int i = 0; i < 4; i++) begin
                    if (i < n)
                        chk(mem[8'(sub+i)] == dgen(c,i,f), "R4", "data byte", mem[8'(sub+i)], dgen(c,i,f));
                end
                chk(mem[8'(sub+n)] == 8'h5A, "R4", "sentinel after burst", mem[8'(sub+n)], 8'h5A);
                chk(hmin == 2*(f ? QF : QS) && hmax == 2*(f ? QF : QS), "R7", "clock high width",
                    hmax, 2*(f ? QF : QS));
            end
        end

        // reads at several indexes and both rates
        for (int f = 0; f < 2; f++) begin
            for (int k = 0; k < 3; k++) begin
                logic [7:0] sub;
                logic [7:0] v;
                sub = (k == 0) ? 8'h00 : (k == 1) ? 8'h7F : 8'hFE;
                v = sub ^ 8'h96 ^ 8'(f*8'h21);
                clear_bus();
                mem[sub] = v;
                launch(1'b1, f[0], SLV, 3'd5, {32'hFFEE_DDCC, sub});
                wait_ready();
                chk(rd_data_o == v, "R5", "read byte", rd_data_o, v);
                chk(err_o == 1'b0, "R5", "no error", err_o, 0);
                chk(starts == 2 && stops == 2, "R2", "read framing", starts*16+stops, 34);
                chk(addr_seen == {SLV, 1'b1}, "R3", "read address byte", addr_seen, {SLV, 1'b1});
                chk(mack == 1'b1, "R5", "no master acknowledge", mack, 1);
                chk(wrbytes == 0 && mem[sub] == v, "R5", "no register written", wrbytes, 0);
                chk(hmax == 2*(f ? QF : QS), "R7", "read clock width", hmax, 2*(f ? QF : QS));
            end
        end

        // missing acknowledge on address
        clear_bus();
        launch(1'b0, 1'b1, 7'h3D, 3'd4, {32'h11223344, 8'h40});
        wait_ready();
        chk(err_o == 1'b1, "R6", "address nack error", err_o, 1);
        chk(wrbytes == 0 && stops == 1, "R6", "address nack abort", wrbytes*16+stops, 1);
        chk(ready_o == 1'b1, "R6", "ready after abort", ready_o, 1);

        // missing acknowledge on second data byte
        clear_bus();
        nack_at = 3;
        launch(1'b0, 1'b1, SLV, 3'd4, {32'h11223344, 8'h40});
        wait_ready();
        nack_at = -1;
        chk(err_o == 1'b1, "R6", "data nack error", err_o, 1);
        chk(wrbytes == 1 && mem[8'h40] == 8'h44, "R6", "bytes before nack", wrbytes, 1);
        chk(mem[8'h41] == 8'h5A && mem[8'h42] == 8'h5A, "R6", "no byte after nack", mem[8'h42], 8'h5A);
        chk(starts == 1 && stops == 1, "R6", "stop after nack", starts*16+stops, 17);

        // next clean transaction clears the error flag
        clear_bus();
        launch(1'b0, 1'b1, SLV, 3'd1, {32'h0000_0077, 8'h50});
        chk(err_o == 1'b0, "R9", "error cleared at launch", err_o, 0);
        wait_ready();
        chk(err_o == 1'b0 && mem[8'h50] == 8'h77, "R9", "clean write after error", mem[8'h50], 8'h77);

        // launch while busy is ignored
        clear_bus();
        launch(1'b0, 1'b0, SLV, 3'd2, {32'h0000_BBAA, 8'h60});
        repeat (30) @(negedge clk);
        chk(ready_o == 1'b0, "R8", "busy mid transfer", ready_o, 0);
        launch(1'b0, 1'b1, SLV, 3'd4, {32'h9999_9999, 8'h20});
        wait_ready();
        repeat (200) @(negedge clk);
        chk(ready_o == 1'b1 && starts == 1, "R8", "second launch ignored", starts, 1);
        chk(mem[8'h60] == 8'hAA && mem[8'h61] == 8'hBB && mem[8'h20] == 8'h5A, "R8",
            "only first burst stored", mem[8'h20], 8'h5A);
        chk(wrbytes == 2 && hmax == 2*QS, "R7", "rate kept from first launch", hmax, 2*QS);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 190000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule